// File: doc/BRIEF.md
# Fast Bit-Bang GPIO Port

This block puts an 8-bit parallel port on top of a wide GPIO bank. Software changes the port with one register write. The write carries a set field and a clear field, and together they update a shared 8-bit fast output value. Pins are arranged as a matrix: pin `n` belongs to row `n mod 8`. Each row is driven by one bit of the fast value, so every participating pin in a row moves together when that bit changes.

A pin takes part in fast mode only when two conditions hold: its normal output-enable bit is set, and its output mode is not tristate. A participating pin drives the fast bit of its row. Every other pin drives the output of the normal GPIO bank. Turning fast mode off for a pin therefore returns that pin to its normal configuration without any other action.

On the input side, an 8-bit register samples one pad per row. The pad is the lowest-numbered participating pin of that row, and it passes through a two-flop synchronizer before it reaches the register.

Top module: `fast_gpio_port`

## Requirements
- R1: Pin `n` belongs to row `n mod ROWS`. When pin `n` participates, `pad_out[n]` equals `fast_val[n mod ROWS]` in the same cycle. For example, pins 3, 11, 19, 27, 35, 43, 51, 59 and 67 all follow bit 3.
- R2: A cycle with `wr_en` high sets bit `k` of `fast_val` from the next cycle when `wr_set[k]` is 1 and `wr_clr[k]` is 0.
- R3: A cycle with `wr_en` high clears bit `k` of `fast_val` from the next cycle when `wr_clr[k]` is 1. If the set bit for the same position is also 1, the clear takes priority.
- R4: A bit whose set and clear are both 0 keeps its value. `fast_val` holds its value in any cycle where `wr_en` is low.
- R5: A single write with value `v` in `wr_set` and `~v` in `wr_clr` makes `fast_val` equal `v`.
- R6: `fast_act[n]` is 1 exactly when `oe[n]` is 1 and `tri_mode[n]` is 0.
- R7: A pin with `tri_mode` set has no fast behaviour. Its `pad_out` is `gpio_out`, and its pad is never sampled into `fast_in`.
- R8: A pin that does not participate drives `pad_out[n] = gpio_out[n]`. This is also how a pin reverts after fast mode is turned off.
- R9: `fast_in[k]` equals the pad of the lowest-numbered participating pin in row `k` as it was two clock edges earlier.
- R10: A row with no participating pin reads 0 in `fast_in`, two edges later.
- R11: During reset, `fast_val` and `fast_in` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the set/clear register |
| wr_set | input | ROWS | Set field; a 1 sets the matching fast bit |
| wr_clr | input | ROWS | Clear field; a 1 clears the matching fast bit |
| oe | input | NUM_PINS | Output-enable bits of the normal bank |
| tri_mode | input | NUM_PINS | Pin output mode is tristate |
| gpio_out | input | NUM_PINS | Normal GPIO output values |
| pad_in | input | NUM_PINS | Pad input values |
| pad_out | output | NUM_PINS | Output after the fast/normal mux |
| fast_act | output | NUM_PINS | Pin currently participates in fast mode |
| fast_val | output | ROWS | Fast output register |
| fast_in | output | ROWS | Synchronized fast input register |

## Verification
The hardest situation to reach from the ports is a row with several participating pins that hold different pad values. In that case the choice of the lowest-numbered pin is actually visible. A related case is the same row after its lowest pin has been moved to tristate, because the selection must then fall through to the next pin of the row.

The directed stimulus builds both cases on row 3 (pins 11 and 35), and it separately checks the short last rows (pins 72 and 73). A long random phase then toggles the enables, the tristate bits and the pads on every cycle. A behavioural reference model scans the pins in ascending order and delays its result through two stages, and it is compared with the design on every clock.

// File: rtl/fgp_pkg.sv
package fgp_pkg;
  localparam int FGP_ROWS = 8;

  // Row that a pin belongs to.
  function automatic int unsigned row_of(int unsigned pin, int unsigned rows);
    return pin % rows;
  endfunction

  // Next fast value after a set/clear access; clear dominates set.
  function automatic logic [31:0] apply_setclr(logic [31:0] cur, logic [31:0] s,
                                               logic [31:0] c);
    return (cur | s) & ~c;
  endfunction
endpackage

// File: rtl/fgp_out_reg.sv
module fgp_out_reg #(
  parameter int ROWS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ROWS-1:0] wr_set,
  input  logic [ROWS-1:0] wr_clr,
  output logic [ROWS-1:0] val
);
  logic [31:0] nxt32;

  always_comb begin
    nxt32 = fgp_pkg::apply_setclr(32'(val), 32'(wr_set), 32'(wr_clr));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     val <= '0;
    else if (wr_en) val <= nxt32[ROWS-1:0];
  end
endmodule

// File: rtl/fgp_pin_mux.sv
module fgp_pin_mux #(
  parameter int NUM_PINS = 74,
  parameter int ROWS     = 8
) (
  input  logic [NUM_PINS-1:0] oe,
  input  logic [NUM_PINS-1:0] tri_mode,
  input  logic [NUM_PINS-1:0] gpio_out,
  input  logic [ROWS-1:0]     fast_val,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] act
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int ROW = int'(fgp_pkg::row_of(p, ROWS));
    assign act[p]     = oe[p] & ~tri_mode[p];
    assign pad_out[p] = act[p] ? fast_val[ROW] : gpio_out[p];
  end
endmodule

// File: rtl/fgp_in_sel.sv
module fgp_in_sel #(
  parameter int NUM_PINS = 74,
  parameter int ROWS     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] act,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [ROWS-1:0]     raw,
  output logic [ROWS-1:0]     fast_in
);
  logic [ROWS-1:0] stage1;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_comb begin
      logic hit;
      hit    = 1'b0;
      raw[r] = 1'b0;
      for (int p = r; p < NUM_PINS; p += ROWS) begin
        if (!hit && act[p]) begin
          raw[r] = pad_in[p];
          hit    = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1  <= '0;
      fast_in <= '0;
    end else begin
      stage1  <= raw;
      fast_in <= stage1;
    end
  end
endmodule

// File: rtl/fast_gpio_port.sv
module fast_gpio_port #(
  parameter int NUM_PINS = 74,
  parameter int ROWS     = fgp_pkg::FGP_ROWS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ROWS-1:0]     wr_set,
  input  logic [ROWS-1:0]     wr_clr,
  input  logic [NUM_PINS-1:0] oe,
  input  logic [NUM_PINS-1:0] tri_mode,
  input  logic [NUM_PINS-1:0] gpio_out,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] fast_act,
  output logic [ROWS-1:0]     fast_val,
  output logic [ROWS-1:0]     fast_in
);
  // Named internal event for the checker: per-row pad chosen before sync.
  logic [ROWS-1:0] row_raw;

  fgp_out_reg #(.ROWS(ROWS)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_set(wr_set), .wr_clr(wr_clr), .val(fast_val)
  );

  fgp_pin_mux #(.NUM_PINS(NUM_PINS), .ROWS(ROWS)) u_mux (
    .oe(oe), .tri_mode(tri_mode), .gpio_out(gpio_out),
    .fast_val(fast_val), .pad_out(pad_out), .act(fast_act)
  );

  fgp_in_sel #(.NUM_PINS(NUM_PINS), .ROWS(ROWS)) u_in (
    .clk(clk), .rst_n(rst_n), .act(fast_act), .pad_in(pad_in),
    .raw(row_raw), .fast_in(fast_in)
  );
endmodule

// File: rtl/fgp_checker.sv
module fgp_checker #(
  parameter int NUM_PINS = 74,
  parameter int ROWS     = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ROWS-1:0]     wr_set,
  input logic [ROWS-1:0]     wr_clr,
  input logic [NUM_PINS-1:0] oe,
  input logic [NUM_PINS-1:0] tri_mode,
  input logic [NUM_PINS-1:0] gpio_out,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] fast_act,
  input logic [ROWS-1:0]     fast_val,
  input logic [ROWS-1:0]     row_raw,
  input logic [ROWS-1:0]     fast_in
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)           up_cnt <= '0;
    else if (up_cnt != 2) up_cnt <= up_cnt + 2'd1;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((fast_val & $past(wr_set & ~wr_clr)) == $past(wr_set & ~wr_clr)));

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((fast_val & $past(wr_clr)) == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(fast_val));

  assert_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_act & ~oe) == '0 && (fast_act & tri_mode) == '0);

  assert_tristate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & tri_mode) == (gpio_out & tri_mode));

  assert_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2) |-> (fast_in == $past(row_raw, 2)));
endmodule

bind fast_gpio_port fgp_checker #(.NUM_PINS(NUM_PINS), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set), .wr_clr(wr_clr),
  .oe(oe), .tri_mode(tri_mode), .gpio_out(gpio_out), .pad_out(pad_out),
  .fast_act(fast_act), .fast_val(fast_val), .row_raw(row_raw), .fast_in(fast_in)
);

// File: tb/fast_gpio_port_test.sv
module fast_gpio_port_test;
  localparam int NP = 74;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [NR-1:0] wr_set = '0, wr_clr = '0;
  logic [NP-1:0] oe = '0, tri_mode = '0, gpio_out = '0, pad_in = '0;
  logic [NP-1:0] pad_out, fast_act;
  logic [NR-1:0] fast_val, fast_in;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // Reference model state
  logic [NR-1:0] m_val = '0, m_d1 = '0, m_d2 = '0;

  always #4 clk = ~clk;

  fast_gpio_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set), .wr_clr(wr_clr),
    .oe(oe), .tri_mode(tri_mode), .gpio_out(gpio_out), .pad_in(pad_in),
    .pad_out(pad_out), .fast_act(fast_act), .fast_val(fast_val), .fast_in(fast_in)
  );

  function automatic logic [NR-1:0] ref_pick();
    logic [NR-1:0] taken = '0;
    logic [NR-1:0] res = '0;
    for (int n = 0; n < NP; n++) begin
      if (oe[n] && !tri_mode[n] && !taken[n % NR]) begin
        taken[n % NR] = 1'b1;
        res[n % NR] = pad_in[n];
      end
    end
    return res;
  endfunction

  function automatic logic [NP-1:0] ref_pads();
    logic [NP-1:0] r;
    for (int n = 0; n < NP; n++)
      r[n] = (oe[n] && !tri_mode[n]) ? m_val[n % NR] : gpio_out[n];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_val = '0; m_d1 = '0; m_d2 = '0;
    end else begin
      if (wr_en) m_val = (m_val | wr_set) & ~wr_clr;
      m_d2 = m_d1;
      m_d1 = ref_pick();
    end
  end

  task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R4 fast_val vs model", 128'(fast_val), 128'(m_val));
      chk("R8 pad_out vs model", 128'(pad_out), 128'(ref_pads()));
      chk("R6 fast_act vs model", 128'(fast_act), 128'(oe & ~tri_mode));
      chk("R9 fast_in vs model", 128'(fast_in), 128'(m_d2));
    end
  end

  task automatic drive_edge();
    @(posedge clk); #1;
  endtask

  task automatic do_write(logic [NR-1:0] s, logic [NR-1:0] c);
    drive_edge();
    wr_en = 1'b1; wr_set = s; wr_clr = c;
    drive_edge();
    wr_en = 1'b0; wr_set = '0; wr_clr = '0;
    @(negedge clk);
  endtask

  task automatic wait_sync();
    drive_edge(); drive_edge(); @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [95:0] r96;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset fast_val", 128'(fast_val), 128'd0);
    chk("R11 reset fast_in", 128'(fast_in), 128'd0);
    drive_edge();
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);

    do_write(8'hA5, 8'h5A);
    chk("R5 full value write", 128'(fast_val), 128'h A5);
    do_write(8'hFF, 8'h0F);
    chk("R3 clear wins", 128'(fast_val), 128'h F0);
    do_write(8'h01, 8'h00);
    chk("R2 set bit 0", 128'(fast_val), 128'h F1);
    drive_edge(); drive_edge(); @(negedge clk);
    chk("R4 hold without write", 128'(fast_val), 128'h F1);

    // Row 3: pins 11 and 35 participate
    drive_edge();
    oe[35] = 1'b1; oe[11] = 1'b1; gpio_out[35] = 1'b0;
    pad_in[11] = 1'b1; pad_in[35] = 1'b0;
    #1;
    chk("R1 pin 35 follows bit 3", 128'(pad_out[35]), 128'(1'b0));
    do_write(8'h08, 8'h00);
    chk("R1 pin 35 follows set bit 3", 128'(pad_out[35]), 128'(1'b1));
    chk("R1 pin 11 same row", 128'(pad_out[11]), 128'(1'b1));
    chk("R9 lowest pin 11 sampled", 128'(fast_in[3]), 128'(1'b1));

    drive_edge();
    tri_mode[11] = 1'b1; gpio_out[11] = 1'b0;
    wait_sync();
    chk("R7 tristate pin 11 mux", 128'(pad_out[11]), 128'(1'b0));
    chk("R7 tristate pin skipped, pin 35 read", 128'(fast_in[3]), 128'(1'b0));

    drive_edge();
    oe[35] = 1'b0; tri_mode[11] = 1'b0; oe[11] = 1'b0;
    gpio_out[35] = 1'b0;
    wait_sync();
    chk("R8 pin 35 reverts", 128'(pad_out[35]), 128'(1'b0));
    chk("R10 empty row reads 0", 128'(fast_in[3]), 128'(1'b0));

    drive_edge();
    oe[73] = 1'b1; pad_in[73] = 1'b1; oe[72] = 1'b1; pad_in[72] = 1'b1;
    wait_sync();
    chk("R9 pin 72 row 0, pin 73 row 1", 128'(fast_in[1:0]), 128'(2'b11));

    for (int i = 0; i < 400; i++) begin
      drive_edge();
      r96 = {$urandom(), $urandom(), $urandom()}; oe = r96[NP-1:0];
      r96 = {$urandom(), $urandom(), $urandom()}; tri_mode = r96[NP-1:0];
      r96 = {$urandom(), $urandom(), $urandom()}; gpio_out = r96[NP-1:0];
      r96 = {$urandom(), $urandom(), $urandom()}; pad_in = r96[NP-1:0];
      wr_en = 1'($urandom());
      wr_set = 8'($urandom()); wr_clr = 8'($urandom());
    end
    drive_edge();
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule